// File: doc/BRIEF.md
# Transactional Local-Address Classifier

This block sits next to the L1 data cache of a core that runs transactions with lazy versioning. For every load or store made inside a transaction, it decides whether the target address is private to the running thread. Private accesses can then be kept out of the commit packet. Three independent sources can mark an access private:

- **Frame test.** The address falls inside the current stack frame.
- **Page flag.** The translated page entry carries a "thread-private page" flag.
- **Line flag.** The cache line already holds its sticky speculative-local flag. This covers data handed over by reference from another frame.

An access is presented in one cycle with its virtual address and the current stack and frame pointers. The frame test is done at once, and its result is kept in a one-bit state register. Translation and the cache lookup then run in parallel. When the lookup completes, on `lookup_hit`, the block combines:

- the saved frame result,
- the flag bit of the translated page entry,
- the line's current speculative-local flag.

In that same cycle it drives `local_o` and, when the line is not yet flagged, `set_sl_o`. The cache uses `set_sl_o` to set the line's sticky flag. Outside a transaction both outputs stay low.

Top module: `txn_local_classifier`

## Requirements
- R1: An access is frame-local when `stack_ptr <= acc_va < frame_ptr` (unsigned). The stack pointer is inclusive and the frame pointer exclusive. A frame-local access gives `local_o`=1 in its lookup cycle.
- R2: When bit 21 (parameter `LOCAL_BIT`) of `tlb_entry` is 1 in the lookup cycle, `local_o`=1. No other bit of `tlb_entry` affects the result.
- R3: The frame test is taken in the cycle `acc_valid` is high and held until the lookup. Changes to `acc_va`, `stack_ptr` or `frame_ptr` between the access and the lookup have no effect on that access's result.
- R4: When `line_sl`=1 in the lookup cycle of a pending access, `local_o`=1, even if the frame and page tests both fail.
- R5: When the frame, page and line tests all fail, `local_o`=0 and `set_sl_o`=0.
- R6: `set_sl_o`=1 exactly when `local_o`=1 and `line_sl`=0. The block never requests the flag on a line that already has it.
- R7: While `txn_active`=0, `local_o` and `set_sl_o` are 0. An access issued while `txn_active`=0 is never classified.
- R8: The outputs are 0 except in a `lookup_hit` cycle that follows an accepted access. A lookup with no pending access gives 0, whatever `tlb_entry` and `line_sl` carry.
- R9: When `stack_ptr >= frame_ptr` the frame is empty, and no address is frame-local.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_active | input | 1 | A transaction is running |
| acc_valid | input | 1 | A transactional access is issued this cycle |
| acc_va | input | ADDR_W | Virtual address of the access |
| stack_ptr | input | ADDR_W | Stack pointer, the inclusive lower frame bound |
| frame_ptr | input | ADDR_W | Frame pointer, the exclusive upper frame bound |
| lookup_hit | input | 1 | Translation and L1 lookup of the pending access complete this cycle |
| tlb_entry | input | PTE_W | Translated page entry; bit LOCAL_BIT marks a thread-private page |
| line_sl | input | 1 | Current speculative-local flag of the addressed line |
| local_o | output | 1 | The access is thread-local (valid in the lookup cycle) |
| set_sl_o | output | 1 | Request to set the line's speculative-local flag |

## Verification
The assertions check on every cycle the rules that tie the outputs to the port values of the lookup cycle:

- the page flag or the line flag forces `local_o`;
- `set_sl_o` never appears without `local_o` or on a line that is already flagged;
- both outputs stay low outside a transaction or a lookup;
- the saved frame result does not move between accepted accesses.

Only the bench's scenarios can show the points that need a reference model computed at the time of the access:

- the exact inclusive/exclusive frame bounds and the empty frame;
- that pointer changes after the access are ignored;
- that a lookup without an accepted access is silent;
- that the page flag is read from the right bit.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic {
    FRAME_OUT = 1'b0,
    FRAME_IN  = 1'b1
  } frame_state_e;
endpackage

// File: rtl/frame_bound_stage.sv
module frame_bound_stage
  import tlc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] fp,
  output frame_state_e      state_q,
  output logic              in_frame_now
);
  // Two full-width comparators: sp inclusive, fp exclusive.
  function automatic logic in_frame(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  assign in_frame_now = in_frame(va, sp, fp);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= FRAME_OUT;
    else if (capture) state_q <= in_frame_now ? FRAME_IN : FRAME_OUT;
  end

  // R3: the saved result does not move without a new capture
  p_state_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(state_q));

  // R9: an empty frame never produces a frame-local capture
  p_empty_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (sp >= fp)) |=> state_q == FRAME_OUT);
endmodule

// File: rtl/page_local_tap.sv
module page_local_tap #(
  parameter int PTE_W     = 32,
  parameter int LOCAL_BIT = 21
) (
  input  logic [PTE_W-1:0] entry,
  output logic             page_local
);
  logic unused_entry_bits;
  assign unused_entry_bits = ^entry;

  generate
    if (LOCAL_BIT < PTE_W) begin : g_tap
      assign page_local = entry[LOCAL_BIT];
    end else begin : g_none
      assign page_local = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/local_merge.sv
module local_merge (
  input  logic txn_active,
  input  logic lookup_hit,
  input  logic pending,
  input  logic frame_local,
  input  logic page_local,
  input  logic line_sl,
  output logic local_o,
  output logic set_sl_o
);
  // The two one-bit comparators (page flag, line flag) join the saved frame result.
  function automatic logic classify(input logic fr, input logic pg, input logic sl);
    return fr | pg | sl;
  endfunction

  logic active_lookup;
  assign active_lookup = txn_active & lookup_hit & pending;
  assign local_o       = active_lookup & classify(frame_local, page_local, line_sl);
  assign set_sl_o      = local_o & ~line_sl;
endmodule

// File: rtl/txn_local_classifier.sv
module txn_local_classifier
  import tlc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PTE_W     = 32,
  parameter int LOCAL_BIT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_active,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_va,
  input  logic [ADDR_W-1:0] stack_ptr,
  input  logic [ADDR_W-1:0] frame_ptr,
  input  logic              lookup_hit,
  input  logic [PTE_W-1:0]  tlb_entry,
  input  logic              line_sl,
  output logic              local_o,
  output logic              set_sl_o
);
  logic         capture;
  logic         pending_q;
  frame_state_e frame_state;
  logic         frame_now;
  logic         page_local;

  assign capture = acc_valid & txn_active;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= txn_active & (acc_valid | (pending_q & ~lookup_hit));
  end

  frame_bound_stage #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .va(acc_va), .sp(stack_ptr), .fp(frame_ptr),
    .state_q(frame_state), .in_frame_now(frame_now)
  );

  page_local_tap #(.PTE_W(PTE_W), .LOCAL_BIT(LOCAL_BIT)) u_page (
    .entry(tlb_entry), .page_local(page_local)
  );

  local_merge u_merge (
    .txn_active(txn_active), .lookup_hit(lookup_hit), .pending(pending_q),
    .frame_local(frame_state == FRAME_IN), .page_local(page_local),
    .line_sl(line_sl), .local_o(local_o), .set_sl_o(set_sl_o)
  );

  logic unused_frame_now;
  assign unused_frame_now = frame_now;

  // R2: page flag in the lookup cycle forces local
  p_page_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && lookup_hit && pending_q && page_local) |-> local_o);

  // R4: sticky line flag keeps the access local
  p_sticky_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && lookup_hit && pending_q && line_sl) |-> local_o);

  // R6: flag request only for a local access on an unflagged line
  p_set_only_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_sl_o |-> (local_o && !line_sl));

  // R7: nothing outside a transaction
  p_no_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_active |-> (!local_o && !set_sl_o));

  // R8: outputs only in a lookup cycle
  p_lookup_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |-> (!local_o && !set_sl_o));
endmodule

// File: tb/txn_local_classifier_test.sv
module txn_local_classifier_test;
  localparam int AW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_active = 1'b0, acc_valid = 1'b0, lookup_hit = 1'b0, line_sl = 1'b0;
  logic [AW-1:0] acc_va = '0, stack_ptr = '0, frame_ptr = '0;
  logic [PW-1:0] tlb_entry = '0;
  logic local_o, set_sl_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit    q_loc[$];
  bit    q_set[$];
  string q_tag[$];

  always #4 clk = ~clk;

  txn_local_classifier uut (
    .clk(clk), .rst_n(rst_n), .txn_active(txn_active), .acc_valid(acc_valid),
    .acc_va(acc_va), .stack_ptr(stack_ptr), .frame_ptr(frame_ptr),
    .lookup_hit(lookup_hit), .tlb_entry(tlb_entry), .line_sl(line_sl),
    .local_o(local_o), .set_sl_o(set_sl_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops the expected result on every lookup cycle.
  always @(negedge clk) begin
    if (rst_n && lookup_hit) begin
      checks++;
      if (q_loc.size() == 0) begin
        fails++;
        $display("FAIL lookup with empty scoreboard: local=%0b set=%0b expected none", local_o, set_sl_o);
      end else begin
        automatic bit    el = q_loc.pop_front();
        automatic bit    es = q_set.pop_front();
        automatic string tg = q_tag.pop_front();
        if (local_o !== el || set_sl_o !== es) begin
          fails++;
          $display("FAIL %s: local=%0b set=%0b expected local=%0b set=%0b",
                   tg, local_o, set_sl_o, el, es);
        end
      end
    end
  end

  function automatic logic [PW-1:0] pte(input bit loc);
    return loc ? (32'h1 << 21) : 32'hFFDF_FFFF;
  endfunction

  task automatic run_access(input string tag, input logic [AW-1:0] va, sp, fp,
                            input bit pg, sl, txn_acc, txn_lk, input int gap,
                            input logic [AW-1:0] gsp, gfp);
    bit inr, el;
    inr = (va >= sp) && (va < fp);
    el  = txn_acc && txn_lk && (inr || pg || sl);
    @(posedge clk) #1;
    acc_valid = 1; acc_va = va; stack_ptr = sp; frame_ptr = fp; txn_active = txn_acc;
    for (int i = 0; i < gap; i++) begin
      @(posedge clk) #1;
      acc_valid = 0; acc_va = ~va; stack_ptr = gsp; frame_ptr = gfp;
    end
    @(posedge clk) #1;
    acc_valid = 0; acc_va = ~va; stack_ptr = gsp; frame_ptr = gfp;
    txn_active = txn_lk; lookup_hit = 1; tlb_entry = pte(pg); line_sl = sl;
    q_loc.push_back(el); q_set.push_back(el && !sl); q_tag.push_back(tag);
    @(posedge clk) #1;
    lookup_hit = 0; line_sl = 0; tlb_entry = '0; txn_active = 1;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (local_o !== 1'b0 || set_sl_o !== 1'b0) begin
      fails++;
      $display("FAIL reset R8: local=%0b set=%0b expected 0 0", local_o, set_sl_o);
    end
    // R1 bounds
    run_access("R1 mid frame",      32'h1010, 32'h1000, 32'h1100, 0, 0, 1, 1, 0, 32'h1000, 32'h1100);
    run_access("R1 at sp inclusive", 32'h1000, 32'h1000, 32'h1100, 0, 0, 1, 1, 0, 32'h1000, 32'h1100);
    run_access("R1 at fp exclusive", 32'h1100, 32'h1000, 32'h1100, 0, 0, 1, 1, 0, 32'h1000, 32'h1100);
    run_access("R1 below sp",       32'h0FFF, 32'h1000, 32'h1100, 0, 0, 1, 1, 1, 32'h1000, 32'h1100);
    // R2 page flag
    run_access("R2 page flag",      32'h8000, 32'h1000, 32'h1100, 1, 0, 1, 1, 0, 32'h1000, 32'h1100);
    run_access("R2 other bits only", 32'h8000, 32'h1000, 32'h1100, 0, 0, 1, 1, 0, 32'h1000, 32'h1100);
    // R3 pointer changes after the access
    run_access("R3 held in-frame",  32'h2040, 32'h2000, 32'h2100, 0, 0, 1, 1, 3, 32'h0, 32'h0);
    run_access("R3 held out-frame", 32'h3000, 32'h2000, 32'h2100, 0, 0, 1, 1, 2, 32'h0, 32'hFFFF_FFFF);
    // R4 sticky line and R6 no re-request
    run_access("R4 R6 by reference", 32'h9000, 32'h1000, 32'h1100, 0, 1, 1, 1, 0, 32'h1000, 32'h1100);
    run_access("R6 local both flags", 32'h1004, 32'h1000, 32'h1100, 1, 1, 1, 1, 0, 32'h1000, 32'h1100);
    // R5 shared
    run_access("R5 shared",         32'hA000, 32'h1000, 32'h1100, 0, 0, 1, 1, 1, 32'h1000, 32'h1100);
    // R7 outside a transaction
    run_access("R7 txn off at lookup", 32'h1010, 32'h1000, 32'h1100, 1, 1, 1, 0, 0, 32'h1000, 32'h1100);
    run_access("R7 txn off at access", 32'h1010, 32'h1000, 32'h1100, 1, 1, 0, 1, 0, 32'h1000, 32'h1100);
    // R9 empty frame
    run_access("R9 sp equals fp",   32'h1000, 32'h1000, 32'h1000, 0, 0, 1, 1, 0, 32'h1000, 32'h1000);
    run_access("R9 sp above fp",    32'h1080, 32'h1100, 32'h1000, 0, 0, 1, 1, 0, 32'h1100, 32'h1000);
    // R8 lookup without an accepted access
    @(posedge clk) #1;
    txn_active = 1; lookup_hit = 1; tlb_entry = pte(1); line_sl = 1;
    q_loc.push_back(0); q_set.push_back(0); q_tag.push_back("R8 orphan lookup");
    @(posedge clk) #1;
    lookup_hit = 0; line_sl = 0; tlb_entry = '0;
    repeat (2) @(posedge clk);
    if (q_loc.size() != 0) begin
      checks++; fails++;
      $display("FAIL R8 scoreboard left %0d expected 0", q_loc.size());
    end
    finish_run();
  end
endmodule